// File: doc/BRIEF.md
# Coherent Writeback Retire Controller

This block sits on the system-controller side of a coherent processor link. It takes dirty-victim writeback requests from one processor and holds each one as pending, keyed by its 64-byte block address. While the writeback waits for its turn, the block watches the invalidation events the controller sends out. An invalidation that hits the same victim block, and that comes from another agent's read-to-own or write-invalidate, retires the writeback with a cancel reply. In that case no data moves.

A writeback that gets through its hold window with no such hit receives an accept reply. The processor then drives the block over a 128-bit bus in four beats. A beat index gives the current address bits [5:4], and it always starts at zero. The reply channel carries only two codes, accept and cancel, and never a retry or error code. An error on the paired victim read does not change how the writeback is handled. A write failure reported by memory comes back as a one-cycle interrupt flag, not through any reply.

The request, reply and data channels are valid/ready streams. A request is taken only while no writeback is pending: `req_ready` is low from the handshake until the writeback retires. A reply, once valid, holds its code until `rep_ready` takes it. Data beats advance only when `dat_valid` and `dat_ready` are both high, so the processor may insert gaps between beats.

Top module: `wbk_retire_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, and `rep_valid`, `dat_ready` and `wr_fail_irq` are 0.
- R2: `req_ready` is 1 exactly when no writeback is pending. It goes low in the cycle after a request handshake and stays low until the writeback retires.
- R3: If no cancelling invalidation arrives, `rep_valid` rises in the (HOLD_CYC+1)-th cycle after the request handshake cycle, with `rep_code` = 2'b01 (accept).
- R4: A cancelling invalidation is one with `inv_valid`=1 and `inv_remote`=1 whose address bits [AW-1:6] equal those of the pending request. It counts only in cycles 1 to HOLD_CYC after the handshake cycle. When it arrives in cycle k of that window, `rep_valid` rises in cycle k+1 with `rep_code` = 2'b10 (cancel).
- R5: The invalidation compare ignores address bits [5:0]. An invalidation with `inv_remote`=0, or one that differs in any bit above bit 5, does not cancel.
- R6: An invalidation in the request handshake cycle itself, or in any cycle after the hold window, does not cancel.
- R7: `rep_code` is only ever 2'b01 or 2'b10 while `rep_valid` is 1. While `rep_ready` is 0, `rep_valid` and `rep_code` stay unchanged.
- R8: After an accept reply handshake, `dat_ready` is 1 until exactly BEATS (4) beat handshakes have taken place. `dat_beat` gives address bits [5:4] of the current beat, counting 0,1,2,3, and `dat_last` is 1 on beat 3.
- R9: After a cancel reply handshake, no data beat is taken: `dat_ready` stays 0 and `req_ready` returns to 1 in the next cycle.
- R10: `req_rd_err` has no effect on the reply code or its timing.
- R11: A 1 on `wr_fail` makes `wr_fail_irq` 1 for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Writeback request valid |
| req_ready | output | 1 | Request can be taken (no writeback pending) |
| req_addr | input | AW (40) | Victim block address |
| req_rd_err | input | 1 | Paired victim read ended in error (advisory only) |
| inv_valid | input | 1 | Invalidation event this cycle |
| inv_addr | input | AW (40) | Invalidation target address |
| inv_remote | input | 1 | Invalidation caused by another agent's read-to-own or write-invalidate |
| rep_valid | output | 1 | Reply valid |
| rep_ready | input | 1 | Reply taken by the processor side |
| rep_code | output | 2 | 2'b01 accept, 2'b10 cancel |
| dat_valid | input | 1 | Processor presents a data beat |
| dat_ready | output | 1 | Controller takes a data beat |
| dat_beat | output | 2 | Address bits [5:4] of the current beat |
| dat_last | output | 1 | Current beat is the final one |
| wr_fail | input | 1 | Write failure reported by memory |
| wr_fail_irq | output | 1 | Interrupt pulse for a write failure |

## Verification
The bench drives invalidations on the first and last cycles of the hold window and on the cycle just outside it at each end. A design with an off-by-one window would cancel a writeback that should be accepted, or the reverse. It also sends invalidations that match on the block but come from the local agent, and ones that differ only in the low six bits or only in one high bit. A compare with the wrong slice, or one that ignores the source, would give the wrong reply code. Every reply is checked for the cycle it appears in, for zero data beats after a cancel and exactly four after an accept, and for a beat index that starts at zero and rises by one across random gaps in `dat_valid`. A design that leaked a beat after a cancel, or skipped a beat under back-pressure, would be caught by these checks.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_REPLY = 2'd2,
    ST_XFER  = 2'd3
  } wbr_state_e;

  typedef enum logic [1:0] {
    RC_RSVD0  = 2'b00,
    RC_ACCEPT = 2'b01,
    RC_CANCEL = 2'b10,
    RC_RSVD3  = 2'b11
  } wbr_code_e;

  localparam int BLK_LSB = 6;
endpackage

// File: rtl/wbr_match.sv
module wbr_match #(
  parameter int TW = 34
) (
  input  logic          window,
  input  logic [TW-1:0] pend_tag,
  input  logic          inv_valid,
  input  logic          inv_remote,
  input  logic [TW-1:0] inv_tag,
  output logic          hit
);
  logic [TW-1:0] diff;
  assign diff = pend_tag ^ inv_tag;
  assign hit  = window & inv_valid & inv_remote & ~(|diff);
endmodule

// File: rtl/wbr_beat_cnt.sv
module wbr_beat_cnt #(
  parameter int BEATS = 4,
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [BW-1:0] idx,
  output logic          last
);
  localparam logic [BW-1:0] LAST_IDX = BW'(BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)         idx <= '0;
    else if (adv && !last)     idx <= idx + 1'b1;
    else if (adv)              idx <= '0;
  end

  assign last = (idx == LAST_IDX);
endmodule

// File: rtl/wbr_fsm.sv
module wbr_fsm
  import wbr_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       hit,
  input  logic       rep_fire,
  input  logic       xfer_done,
  output wbr_state_e state,
  output wbr_code_e  code
);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      code  <= RC_ACCEPT;
      hcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          hcnt <= '0;
          if (req_fire) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (hit) begin
            state <= ST_REPLY;
            code  <= RC_CANCEL;
          end else if (hcnt == HOLD_END) begin
            state <= ST_REPLY;
            code  <= RC_ACCEPT;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ST_REPLY: begin
          if (rep_fire) state <= (code == RC_ACCEPT) ? ST_XFER : ST_IDLE;
        end
        ST_XFER: begin
          if (xfer_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbk_retire_ctrl.sv
module wbk_retire_ctrl
  import wbr_pkg::*;
#(
  parameter int AW       = 40,
  parameter int DW       = 128,
  parameter int HOLD_CYC = 4,
  localparam int BEATS   = 512 / DW,
  localparam int BW      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int TW      = AW - BLK_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rd_err,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  input  logic          inv_remote,
  output logic          rep_valid,
  input  logic          rep_ready,
  output logic [1:0]    rep_code,
  input  logic          dat_valid,
  output logic          dat_ready,
  output logic [BW-1:0] dat_beat,
  output logic          dat_last,
  input  logic          wr_fail,
  output logic          wr_fail_irq
);
  wbr_state_e    state;
  wbr_code_e     code;
  logic [TW-1:0] pend_tag;
  logic          hit, req_fire, rep_fire, beat_fire, xfer_done;
  logic          unused_bits;

  // The paired read's error status and the in-block offset play no part.
  assign unused_bits = ^{req_rd_err, req_addr[BLK_LSB-1:0], inv_addr[BLK_LSB-1:0]};

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid & req_ready;
  assign rep_valid = (state == ST_REPLY);
  assign rep_code  = code;
  assign rep_fire  = rep_valid & rep_ready;
  assign dat_ready = (state == ST_XFER);
  assign beat_fire = dat_valid & dat_ready;
  assign xfer_done = beat_fire & dat_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_tag <= '0;
    else if (req_fire) pend_tag <= req_addr[AW-1:BLK_LSB];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_fail_irq <= 1'b0;
    else        wr_fail_irq <= wr_fail;
  end

  wbr_match #(.TW(TW)) u_match (
    .window     (state == ST_HOLD),
    .pend_tag   (pend_tag),
    .inv_valid  (inv_valid),
    .inv_remote (inv_remote),
    .inv_tag    (inv_addr[AW-1:BLK_LSB]),
    .hit        (hit)
  );

  wbr_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .hit       (hit),
    .rep_fire  (rep_fire),
    .xfer_done (xfer_done),
    .state     (state),
    .code      (code)
  );

  wbr_beat_cnt #(.BEATS(BEATS)) u_beats (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != ST_XFER),
    .adv   (beat_fire),
    .idx   (dat_beat),
    .last  (dat_last)
  );
endmodule

// File: rtl/wbk_retire_chk.sv
module wbk_retire_chk #(
  parameter int BW = 2,
  parameter int BEATS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rep_valid,
  input logic          rep_ready,
  input logic [1:0]    rep_code,
  input logic          dat_valid,
  input logic          dat_ready,
  input logic [BW-1:0] dat_beat,
  input logic          dat_last,
  input logic          wr_fail,
  input logic          wr_fail_irq
);
  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (rep_code == 2'b01 || rep_code == 2'b10));

  p_reply_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_code)));

  p_busy_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid || dat_ready) |-> !req_ready);

  p_req_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_cancel_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_ready && rep_code == 2'b10) |=> (!dat_ready && req_ready));

  p_accept_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && rep_ready && rep_code == 2'b01) |=> (dat_ready && dat_beat == '0));

  p_beat_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && dat_ready && !dat_last) |=> (dat_ready && dat_beat == $past(dat_beat) + 1'b1));

  p_last_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_ready && dat_last) |-> (dat_beat == BW'(BEATS - 1)));

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fail |=> wr_fail_irq);
endmodule

bind wbk_retire_ctrl wbk_retire_chk #(.BW(BW), .BEATS(BEATS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rep_valid   (rep_valid),
  .rep_ready   (rep_ready),
  .rep_code    (rep_code),
  .dat_valid   (dat_valid),
  .dat_ready   (dat_ready),
  .dat_beat    (dat_beat),
  .dat_last    (dat_last),
  .wr_fail     (wr_fail),
  .wr_fail_irq (wr_fail_irq)
);

// File: tb/wbk_retire_ctrl_bench.sv
module wbk_retire_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int H = 4;
  localparam int BEATS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_rd_err = 1'b0;
  logic [AW-1:0] req_addr = '0, inv_addr = '0;
  logic          inv_valid = 1'b0, inv_remote = 1'b0;
  logic          rep_ready = 1'b0, dat_valid = 1'b0, wr_fail = 1'b0;
  logic          req_ready, rep_valid, dat_ready, dat_last, wr_fail_irq;
  logic [1:0]    rep_code, dat_beat;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbk_retire_ctrl #(.AW(AW), .DW(128), .HOLD_CYC(H)) u_wbk_retire_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd_err(req_rd_err), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .inv_remote(inv_remote), .rep_valid(rep_valid),
    .rep_ready(rep_ready), .rep_code(rep_code), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_beat(dat_beat), .dat_last(dat_last),
    .wr_fail(wr_fail), .wr_fail_irq(wr_fail_irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // mode: 0 none, 1 same block remote, 2 same block local,
  //       3 remote differing only in [5:0], 4 remote differing above bit 5
  function automatic bit exp_cancel(input int mode, input int k);
    return (mode == 1 || mode == 3) && k >= 1 && k <= H;
  endfunction

  function automatic string tag_for(input int mode, input int k, input bit rderr);
    if (mode == 2 || mode == 4) return "R5";
    if (mode == 3 && exp_cancel(mode, k)) return "R5";
    if (mode != 0 && !exp_cancel(mode, k)) return "R6";
    if (mode != 0) return "R4";
    if (rderr) return "R10";
    return "R3";
  endfunction

  function automatic logic [AW-1:0] inv_for(input int mode, input logic [AW-1:0] a, input int sel);
    case (mode)
      3:       return {a[AW-1:6], ~a[5:0]};
      4:       return a ^ (40'd1 << (6 + (sel % (AW - 6))));
      default: return a;
    endcase
  endfunction

  task automatic run_wb(input logic [AW-1:0] a, input bit rderr, input int mode,
                        input int k, input int rdly, input int sel);
    bit can = exp_cancel(mode, k);
    string tg = tag_for(mode, k, rderr);
    int first_rep = -1;
    int waited = 0;
    int beats = 0;
    bit rep_done = 0;
    bit fin = 0;
    logic [1:0] code = 2'b00;
    int c = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R2", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_rd_err = rderr;
    inv_valid = (mode != 0 && k == 0);
    inv_remote = (mode != 2);
    inv_addr = inv_for(mode, a, sel);
    while (!fin && c < 200) begin
      @(negedge clk);
      c++;
      req_valid = 1'b0; rep_ready = 1'b0; dat_valid = 1'b0;
      inv_valid = (mode != 0 && c == k);
      if (c == 1) check(req_ready == 1'b0, "R2", req_ready, 0);
      if (!rep_done) begin
        if (rep_valid) begin
          if (first_rep < 0) first_rep = c;
          if (waited == rdly) begin
            rep_ready = 1'b1; code = rep_code; rep_done = 1'b1;
          end else waited++;
        end
      end else if (code == 2'b01 && beats < BEATS) begin
        check(dat_ready == 1'b1, "R8", dat_ready, 1);
        check(dat_beat == beats[1:0], "R8", dat_beat, beats);
        check(dat_last == (beats == BEATS-1), "R8", dat_last, beats == BEATS-1);
        if ($urandom % 4 != 0) begin dat_valid = 1'b1; beats++; end
      end else begin
        check(dat_ready == 1'b0, can ? "R9" : "R8", dat_ready, 0);
        check(req_ready == 1'b1, "R2", req_ready, 1);
        fin = 1'b1;
      end
    end
    inv_valid = 1'b0;
    check(code == (can ? 2'b10 : 2'b01), tg, code, can ? 2 : 1);
    check(first_rep == (can ? k + 1 : H + 1), tg, first_rep, can ? k + 1 : H + 1);
    check(beats == (can ? 0 : BEATS), can ? "R9" : "R8", beats, can ? 0 : BEATS);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", req_ready, 1);
    check(rep_valid == 1'b0, "R1", rep_valid, 0);
    check(dat_ready == 1'b0, "R1", dat_ready, 0);
    check(wr_fail_irq == 1'b0, "R1", wr_fail_irq, 0);
    rst_n = 1'b1;

    run_wb(40'h12_3456_7880, 0, 0, 0, 0, 0);   // R3 plain accept
    run_wb(40'h00_0000_0040, 0, 1, 1, 0, 0);   // R4 window start
    run_wb(40'hFF_FFFF_FFC0, 0, 1, H, 2, 0);   // R4 window end
    run_wb(40'h55_AAAA_5500, 0, 1, H + 1, 0, 0); // R6 just after
    run_wb(40'h55_AAAA_5500, 0, 1, 0, 0, 0);   // R6 handshake cycle
    run_wb(40'h0A_0B0C_0D00, 0, 2, 2, 0, 0);   // R5 local source
    run_wb(40'h0A_0B0C_0D00, 0, 3, 2, 1, 0);   // R5 low bits ignored
    run_wb(40'h0A_0B0C_0D00, 0, 4, 3, 0, 33);  // R5 top bit differs
    run_wb(40'h77_7777_7700, 1, 0, 0, 5, 0);   // R10 read error
    run_wb(40'h77_7777_7700, 1, 1, 2, 0, 0);   // R10 with cancel

    // R11 interrupt pulse
    @(negedge clk); wr_fail = 1'b1;
    @(negedge clk); wr_fail = 1'b0;
    check(wr_fail_irq == 1'b1, "R11", wr_fail_irq, 1);
    @(negedge clk);
    check(wr_fail_irq == 1'b0, "R11", wr_fail_irq, 0);

    for (int i = 0; i < 80; i++) begin
      logic [AW-1:0] a = {$urandom, $urandom} & {AW{1'b1}};
      run_wb(a, 1'($urandom), int'($urandom % 5), int'($urandom % (H + 3)),
             int'($urandom % 4), int'($urandom % 64));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule